// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flags

This block is the purely combinational arithmetic and logic unit of an 8-bit accumulator machine. Each cycle it takes the accumulator, one operand byte, the current flag byte and a 5-bit operation code. From these it produces the new result byte and the new flag byte. The flag byte carries sign, zero, auxiliary (half) carry, parity and carry. A separate 16-bit adder path supplies the sum and carry for register-pair additions.

The surrounding datapath decides what to do with the outputs. It writes `result_o` back to the accumulator, or to the incremented or decremented register. It always latches `flags_o`. For operations that only touch flags, `result_o` simply returns the accumulator unchanged.

Top module: `alu8_core`

## Requirements
- R1: `flags_o` packs sign at bit 7, zero at bit 6, auxiliary carry at bit 4, parity at bit 2 and carry at bit 0. Bit 1 is always 1, and bits 5 and 3 are always 0, whatever `flags_i` holds.
- R2: Codes 0 to 7 select add, add-with-carry, subtract, subtract-with-borrow, AND, XOR, OR and compare, each taking the accumulator and the operand. Whenever an operation updates sign, zero and parity, it takes them from its result byte: sign is bit 7, zero means the byte equals 0, and parity is 1 for an even count of 1 bits.
- R3: Add (0) and add-with-carry (1) compute acc + opd + cin, where cin is `flags_i` bit 0 for code 1 and 0 for code 0. Carry is bit 8 of that sum, and auxiliary carry is the carry out of bit 3.
- R4: Subtract (2) and subtract-with-borrow (3) compute acc - opd - cin, with cin taken as in R3. Carry is the borrow, which is bit 8 of the 9-bit difference. Auxiliary carry is bit 4 of acc XOR opd XOR difference.
- R5: Compare (7) sets every flag exactly as subtract does, and returns the unchanged accumulator on `result_o`.
- R6: AND clears carry and sets auxiliary carry to bit 3 of (acc OR opd). XOR and OR clear both carry and auxiliary carry.
- R7: Increment (8) and decrement (9) act on the operand byte and leave carry unchanged. On increment, auxiliary carry is 1 only when the low nibble of the result is 0. On decrement, auxiliary carry is 1 unless the low nibble of the result is 0xF.
- R8: Code 10 rotates left circular, code 11 rotates right circular, code 12 rotates left through carry and code 13 rotates right through carry. In the circular forms, the bit that leaves the byte goes both to the opposite end and into carry. In the through-carry forms, the old carry enters the byte and the bit that leaves goes into carry. No other flag changes.
- R9: Decimal adjust (14) adds a correction to the accumulator. The correction includes 0x06 when auxiliary carry is set or the low nibble exceeds 9. It includes 0x60 when carry is set, when the high nibble exceeds 9, or when the high nibble is at least 9 and the low nibble exceeds 9. Sign, zero, parity and auxiliary carry come from that addition, as in R3. Carry becomes 1 when 0x60 is added and otherwise keeps its input value.
- R10: Complement (15) returns the inverted accumulator and leaves all flags unchanged. Set-carry (16) forces carry to 1. Complement-carry (17) inverts carry. Codes 16 and 17 return the unchanged accumulator and change no other flag.
- R11: `pair_sum_o` always presents the low 16 bits of `pair_a_i + pair_b_i`. For code 18, carry takes bit 16 of that sum, all other flags are unchanged, and `result_o` returns the accumulator.
- R12: Codes 19 to 31 return the unchanged accumulator and leave all flags unchanged, apart from the fixed bits of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator value |
| opd_i | input | 8 | Operand byte (register, memory or immediate) |
| flags_i | input | 8 | Current flag byte |
| op_i | input | 5 | Operation code |
| pair_a_i | input | 16 | First register-pair addend |
| pair_b_i | input | 16 | Second register-pair addend |
| result_o | output | 8 | New result byte |
| flags_o | output | 8 | New flag byte |
| pair_sum_o | output | 16 | Low 16 bits of the pair sum |

## Verification
There is no register anywhere in the block, so every output becomes valid within the same cycle that its inputs are applied. The bench drives a new input set just after each rising clock edge and samples `result_o`, `flags_o` and `pair_sum_o` at the following falling edge. It compares them there against a behavioural model evaluated on the same inputs. Directed vectors cover the carry, borrow, nibble and decimal-adjust corner cases, and a long random sweep covers all 32 operation codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW  = 8;
  localparam int WW  = 16;
  localparam int OPW = 5;

  localparam int F_S = 7;
  localparam int F_Z = 6;
  localparam int F_H = 4;
  localparam int F_P = 2;
  localparam int F_C = 0;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBB  = 5'd3,
    OP_AND  = 5'd4,
    OP_XOR  = 5'd5,
    OP_OR   = 5'd6,
    OP_CMP  = 5'd7,
    OP_INC  = 5'd8,
    OP_DEC  = 5'd9,
    OP_RLC  = 5'd10,
    OP_RRC  = 5'd11,
    OP_RAL  = 5'd12,
    OP_RAR  = 5'd13,
    OP_DAA  = 5'd14,
    OP_CMA  = 5'd15,
    OP_STC  = 5'd16,
    OP_CMC  = 5'd17,
    OP_ADDW = 5'd18
  } alu_op_e;

  function automatic logic [7:0] pack_flags(input logic s, input logic z,
                                            input logic h, input logic p,
                                            input logic c);
    return {s, z, 1'b0, h, 1'b0, p, 1'b1, c};
  endfunction
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int DW = 8,
  localparam int HB = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o,
  output logic          half_o
);
  logic [DW:0] r_w;

  always_comb begin
    if (sub_i) r_w = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, cin_i};
    else       r_w = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
    res_o  = r_w[DW-1:0];
    cout_o = r_w[DW];
    half_o = a_i[HB] ^ b_i[HB] ^ r_w[HB];
  end

  always_comb begin
    if (!sub_i) begin
      p_half_nibble_r3: assert (half_o ==
        (({1'b0, a_i[HB-1:0]} + {1'b0, b_i[HB-1:0]} + {{HB{1'b0}}, cin_i}) > 5'd15));
    end else begin
      p_borrow_r4: assert (cout_o ==
        ({1'b0, a_i} < ({1'b0, b_i} + {{DW{1'b0}}, cin_i})));
    end
  end
endmodule

// File: rtl/alu8_rot.sv
module alu8_rot #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic          cin_i,
  input  logic [1:0]    sel_i,   // 0 rl circ, 1 rr circ, 2 rl thru c, 3 rr thru c
  output logic [DW-1:0] res_o,
  output logic          cout_o
);
  always_comb begin
    case (sel_i)
      2'd0: begin res_o = {a_i[DW-2:0], a_i[DW-1]}; cout_o = a_i[DW-1]; end
      2'd1: begin res_o = {a_i[0], a_i[DW-1:1]};    cout_o = a_i[0];    end
      2'd2: begin res_o = {a_i[DW-2:0], cin_i};     cout_o = a_i[DW-1]; end
      default: begin res_o = {cin_i, a_i[DW-1:1]};  cout_o = a_i[0];    end
    endcase
  end

  always_comb begin
    if (!sel_i[1]) begin
      p_circ_ones_r8: assert ($countones(res_o) == $countones(a_i));
    end else begin
      p_thru_ones_r8: assert (($countones(res_o) + int'(cout_o)) ==
                              ($countones(a_i) + int'(cin_i)));
    end
  end
endmodule

// File: rtl/alu8_daa.sv
module alu8_daa #(
  parameter int DW = 8,
  localparam int NW = DW / 2
) (
  input  logic [DW-1:0] a_i,
  input  logic          h_i,
  input  logic          c_i,
  output logic [DW-1:0] corr_o,
  output logic          force_c_o
);
  logic [NW-1:0] lo_w, hi_w;
  logic          lo_big, hi_fix;

  always_comb begin
    lo_w   = a_i[NW-1:0];
    hi_w   = a_i[DW-1:NW];
    lo_big = lo_w > NW'(9);
    hi_fix = c_i || (hi_w > NW'(9)) || ((hi_w >= NW'(9)) && lo_big);
    corr_o = {(hi_fix ? NW'(6) : NW'(0)), ((h_i || lo_big) ? NW'(6) : NW'(0))};
    force_c_o = hi_fix;
  end

  always_comb begin
    p_corr_shape_r9: assert (corr_o[3] == 1'b0 && corr_o[0] == 1'b0 && corr_o[7] == 1'b0
                             && corr_o[2] == corr_o[1] && corr_o[6] == corr_o[5]);
    p_force_high_r9: assert (force_c_o == corr_o[6]);
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  opd_i,
  input  logic [7:0]     flags_i,
  input  logic [OPW-1:0] op_i,
  input  logic [WW-1:0]  pair_a_i,
  input  logic [WW-1:0]  pair_b_i,
  output logic [DW-1:0]  result_o,
  output logic [7:0]     flags_o,
  output logic [WW-1:0]  pair_sum_o
);
  logic [DW-1:0] sum_w, dsum_w, rot_w, corr_w, szp_src;
  logic          sum_c, sum_h, dsum_c, dsum_h, rot_c, force_c;
  logic          use_cin, is_sub;
  logic [1:0]    rot_sel;
  logic [WW:0]   wsum_w;

  assign use_cin = (op_i == OP_ADC) || (op_i == OP_SBB);
  assign is_sub  = (op_i == OP_SUB) || (op_i == OP_SBB) || (op_i == OP_CMP);
  assign rot_sel = 2'(op_i - OP_RLC);
  assign wsum_w  = {1'b0, pair_a_i} + {1'b0, pair_b_i};
  assign pair_sum_o = wsum_w[WW-1:0];

  alu8_adder #(.DW(DW)) u_main (
    .a_i(acc_i), .b_i(opd_i), .cin_i(use_cin & flags_i[F_C]), .sub_i(is_sub),
    .res_o(sum_w), .cout_o(sum_c), .half_o(sum_h));

  alu8_daa #(.DW(DW)) u_daa (
    .a_i(acc_i), .h_i(flags_i[F_H]), .c_i(flags_i[F_C]),
    .corr_o(corr_w), .force_c_o(force_c));

  alu8_adder #(.DW(DW)) u_adj (
    .a_i(acc_i), .b_i(corr_w), .cin_i(1'b0), .sub_i(1'b0),
    .res_o(dsum_w), .cout_o(dsum_c), .half_o(dsum_h));

  alu8_rot #(.DW(DW)) u_rot (
    .a_i(acc_i), .cin_i(flags_i[F_C]), .sel_i(rot_sel),
    .res_o(rot_w), .cout_o(rot_c));

  logic s_n, z_n, h_n, p_n, c_n, upd;
  logic [DW-1:0] res_n;
  logic          unused_dc;
  assign unused_dc = dsum_c;

  always_comb begin
    res_n   = acc_i;
    s_n     = flags_i[F_S];
    z_n     = flags_i[F_Z];
    h_n     = flags_i[F_H];
    p_n     = flags_i[F_P];
    c_n     = flags_i[F_C];
    upd     = 1'b0;
    szp_src = '0;
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        res_n = sum_w; h_n = sum_h; c_n = sum_c; upd = 1'b1; szp_src = sum_w;
      end
      OP_CMP: begin
        h_n = sum_h; c_n = sum_c; upd = 1'b1; szp_src = sum_w;
      end
      OP_AND: begin
        res_n = acc_i & opd_i; h_n = acc_i[3] | opd_i[3]; c_n = 1'b0;
        upd = 1'b1; szp_src = acc_i & opd_i;
      end
      OP_XOR: begin
        res_n = acc_i ^ opd_i; h_n = 1'b0; c_n = 1'b0; upd = 1'b1; szp_src = acc_i ^ opd_i;
      end
      OP_OR: begin
        res_n = acc_i | opd_i; h_n = 1'b0; c_n = 1'b0; upd = 1'b1; szp_src = acc_i | opd_i;
      end
      OP_INC: begin
        res_n = opd_i + DW'(1); h_n = (res_n[3:0] == 4'h0); upd = 1'b1; szp_src = res_n;
      end
      OP_DEC: begin
        res_n = opd_i - DW'(1); h_n = (res_n[3:0] != 4'hF); upd = 1'b1; szp_src = res_n;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        res_n = rot_w; c_n = rot_c;
      end
      OP_DAA: begin
        res_n = dsum_w; h_n = dsum_h; c_n = flags_i[F_C] | force_c;
        upd = 1'b1; szp_src = dsum_w;
      end
      OP_CMA:  res_n = ~acc_i;
      OP_STC:  c_n = 1'b1;
      OP_CMC:  c_n = ~flags_i[F_C];
      OP_ADDW: c_n = wsum_w[WW];
      default: ;
    endcase
    if (upd) begin
      s_n = szp_src[DW-1];
      z_n = (szp_src == '0);
      p_n = ~^szp_src;
    end
    result_o = res_n;
    flags_o  = pack_flags(s_n, z_n, h_n, p_n, c_n);
  end

  always_comb begin
    p_fixed_bits_r1: assert (flags_o[5] == 1'b0 && flags_o[3] == 1'b0 && flags_o[1] == 1'b1);
    if (op_i >= OP_RLC && op_i <= OP_RAR) begin
      p_rot_keep_r8: assert (flags_o[7:1] ==
        {flags_i[7:6], 1'b0, flags_i[4], 1'b0, flags_i[2], 1'b1});
    end
    if (op_i == OP_INC || op_i == OP_DEC) begin
      p_incdec_carry_r7: assert (flags_o[0] == flags_i[0]);
    end
    if (op_i == OP_CMP) begin
      p_cmp_keeps_acc_r5: assert (result_o == acc_i);
    end
    if (op_i == OP_CMA) begin
      p_cma_invert_r10: assert ((result_o ^ acc_i) == '1);
    end
  end
endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  acc, opd, fin;
  logic [4:0]  op;
  logic [15:0] pa, pb;
  logic [7:0]  res, fout;
  logic [15:0] psum;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  alu8_core u0 (
    .acc_i(acc), .opd_i(opd), .flags_i(fin), .op_i(op),
    .pair_a_i(pa), .pair_b_i(pb),
    .result_o(res), .flags_o(fout), .pair_sum_o(psum));

  function automatic string tag_of(int o);
    if (o <= 1) return "R3";
    if (o <= 3) return "R4";
    if (o <= 6) return "R6";
    if (o == 7) return "R5";
    if (o <= 9) return "R7";
    if (o <= 13) return "R8";
    if (o == 14) return "R9";
    if (o <= 17) return "R10";
    if (o == 18) return "R11";
    return "R12";
  endfunction

  // returns {result, flags}
  function automatic logic [15:0] model(int a, int b, int f, int o, int wa, int wb);
    int r, s, z, h, p, c, t, src, cin, lo, hi, add, fc;
    bit upd;
    r = a; s = (f >> 7) & 1; z = (f >> 6) & 1; h = (f >> 4) & 1;
    p = (f >> 2) & 1; c = f & 1; upd = 0; src = 0;
    cin = (o == 1 || o == 3) ? c : 0;
    case (o)
      0, 1: begin
        t = a + b + cin; r = t & 255; h = ((a & 15) + (b & 15) + cin) > 15 ? 1 : 0;
        c = t > 255 ? 1 : 0; upd = 1; src = r;
      end
      2, 3, 7: begin
        t = a - b - cin; src = t & 255; h = ((a ^ b ^ t) >> 4) & 1;
        c = t < 0 ? 1 : 0; upd = 1;
        if (o != 7) r = src;
      end
      4: begin r = a & b; h = ((a | b) >> 3) & 1; c = 0; upd = 1; src = r; end
      5: begin r = a ^ b; h = 0; c = 0; upd = 1; src = r; end
      6: begin r = a | b; h = 0; c = 0; upd = 1; src = r; end
      8: begin r = (b + 1) & 255; h = (r & 15) == 0 ? 1 : 0; upd = 1; src = r; end
      9: begin r = (b + 255) & 255; h = (r & 15) != 15 ? 1 : 0; upd = 1; src = r; end
      10: begin c = (a >> 7) & 1; r = ((a << 1) | c) & 255; end
      11: begin c = a & 1; r = (a >> 1) | (c << 7); end
      12: begin t = (a >> 7) & 1; r = ((a << 1) | c) & 255; c = t; end
      13: begin t = a & 1; r = (a >> 1) | (c << 7); c = t; end
      14: begin
        lo = a & 15; hi = a >> 4; add = 0; fc = c;
        if (h == 1 || lo > 9) add = 6;
        if (c == 1 || hi > 9 || (hi >= 9 && lo > 9)) begin add = add | 96; fc = 1; end
        t = a + add; r = t & 255; h = ((a & 15) + (add & 15)) > 15 ? 1 : 0;
        c = fc; upd = 1; src = r;
      end
      15: r = (~a) & 255;
      16: c = 1;
      17: c = c ^ 1;
      18: c = ((wa + wb) >> 16) & 1;
      default: ;
    endcase
    if (upd) begin
      s = (src >> 7) & 1; z = (src == 0) ? 1 : 0;
      p = ($countones(8'(src)) % 2 == 0) ? 1 : 0;
    end
    return {8'(r), 8'((s << 7) | (z << 6) | (h << 4) | (p << 2) | 2 | c)};
  endfunction

  task automatic check8(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s op=%0d acc=%h opd=%h fin=%h actual=%h expected=%h",
               req, what, op, acc, opd, fin, act, exp);
    end
  endtask

  task automatic apply(int a, int b, int f, int o, int wa, int wb);
    logic [15:0] e;
    @(posedge clk);
    acc = 8'(a); opd = 8'(b); fin = 8'(f); op = 5'(o); pa = 16'(wa); pb = 16'(wb);
    @(negedge clk);
    e = model(a, b, f, o, wa, wb);
    check8((o < 8) ? "R2" : tag_of(o), "result", {8'h0, res}, {8'h0, e[15:8]});
    check8(tag_of(o), "flags", {8'h0, fout}, {8'h0, e[7:0]});
    check8("R1", "fixed", {13'h0, fout[5], fout[3], fout[1]}, 16'h0001);
    check8("R11", "pairsum", psum, 16'(wa + wb));
  endtask

  initial begin
    acc = 0; opd = 0; fin = 0; op = 0; pa = 0; pb = 0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset-state inputs all zero: add of 0+0 gives zero, even parity
    check8("R2", "reset result", {8'h0, res}, 16'h0000);
    check8("R1", "reset flags", {8'h0, fout}, 16'h0046);
    // R3 carry and half carry
    apply(8'hFF, 8'h01, 8'h00, 0, 0, 0);
    apply(8'h0F, 8'h00, 8'h01, 1, 0, 0);
    // R4 borrow
    apply(8'h00, 8'h01, 8'h00, 2, 0, 0);
    apply(8'h10, 8'h0F, 8'h01, 3, 0, 0);
    // R5 compare equal and less
    apply(8'h42, 8'h42, 8'h00, 7, 0, 0);
    apply(8'h41, 8'h42, 8'h00, 7, 0, 0);
    // R6 logic ops with carry set on input
    apply(8'h08, 8'h00, 8'h11, 4, 0, 0);
    apply(8'hF0, 8'h0F, 8'h11, 5, 0, 0);
    apply(8'h00, 8'h00, 8'h11, 6, 0, 0);
    // R7 nibble boundaries
    apply(8'h00, 8'h0F, 8'h01, 8, 0, 0);
    apply(8'h00, 8'hFF, 8'h00, 8, 0, 0);
    apply(8'h00, 8'h10, 8'h01, 9, 0, 0);
    apply(8'h00, 8'h00, 8'h00, 9, 0, 0);
    // R8 rotates with both carry values
    for (int o = 10; o <= 13; o++) begin
      apply(8'h81, 0, 8'h00, o, 0, 0);
      apply(8'h81, 0, 8'hFF, o, 0, 0);
    end
    // R9 decimal adjust corners
    apply(8'h9A, 0, 8'h00, 14, 0, 0);
    apply(8'h99, 0, 8'h10, 14, 0, 0);
    apply(8'hA0, 0, 8'h00, 14, 0, 0);
    apply(8'h15, 0, 8'h01, 14, 0, 0);
    apply(8'h45, 0, 8'h00, 14, 0, 0);
    // R10
    apply(8'h5A, 0, 8'hD5, 15, 0, 0);
    apply(8'h5A, 0, 8'h00, 16, 0, 0);
    apply(8'h5A, 0, 8'h01, 17, 0, 0);
    // R11 pair carry
    apply(8'h33, 0, 8'hD4, 18, 16'hFFFF, 16'h0001);
    apply(8'h33, 0, 8'h01, 18, 16'h1234, 16'h0101);
    // R12 unused codes keep everything, input fixed bits scrambled
    apply(8'hC3, 8'h3C, 8'h2A, 19, 0, 0);
    apply(8'hC3, 8'h3C, 8'hFD, 31, 0, 0);
    // random sweep over all codes
    for (int i = 0; i < 4000; i++) begin
      apply(int'($urandom_range(255)), int'($urandom_range(255)), int'($urandom_range(255)),
            int'($urandom_range(31)), int'($urandom_range(65535)), int'($urandom_range(65535)));
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule